// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

This block is a clock-driven, synthesizable stand-in for a 16-bit-wide asynchronous static memory with pin-level control. It decodes a pair of chip selects of opposite polarity, an active-low output enable, an active-low write enable and two active-low byte-lane enables. From these it decides whether the part is idle (standby), selected with its outputs off, reading, or writing. Reads and writes may cover the whole word or a single byte.

The data bus is split into a write-data input and a read-data output. Tri-state pads are modelled by a per-lane drive flag, and a lane that is not driven reads back as zero. A two-bit mode output exposes the decoded state so that a surrounding bench can check the decode directly. Writes commit on the simulation clock edge. Reads are combinational from the array. The full part holds 2^18 words. The address width is a parameter, which keeps the default array small enough for simulation.

Top module: `sram_lane_model`

## Requirements
- R1: The array holds 2^ADDR_W independent 16-bit words (default ADDR_W=10, up to 18). A word written at one address never changes the word at another address.
- R2: The part is selected only when cs_lo_n=0 and cs_hi=1. Otherwise mode=2'b00 (standby), drive=2'b00, rdata=0, and no write occurs, whatever the other controls are.
- R3: With both byte enables high (lb_n=1, ub_n=1), mode=2'b00 and drive=2'b00 even when both chip selects are asserted, and no write occurs.
- R4: lb_n governs data bits 7:0 and drive[0]. ub_n governs data bits 15:8 and drive[1]. This holds for reads and for writes.
- R5: When the part is selected with we_n=0 and at least one byte enable low, mode=2'b11. At the next rising clock edge, only the enabled lanes of the addressed word take wdata. oe_n has no effect on the write.
- R6: When the part is selected with we_n=1 and oe_n=0, mode=2'b10. drive equals the enabled lanes. rdata carries the stored byte on each driven lane and zero on each undriven lane, in the same cycle as the address.
- R7: When the part is selected with we_n=1 and oe_n=1, mode=2'b01, drive=2'b00 and rdata=0.
- R8: While rst=1, no write commits, although mode and drive still follow the pins.
- R9: A write shows no read data in its own cycle (drive=2'b00). The new contents are readable from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Simulation clock; writes commit on its rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks writes |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| cs_lo_n | input | 1 | Chip select, active low |
| cs_hi | input | 1 | Chip select, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lb_n | input | 1 | Lower byte enable (bits 7:0), active low |
| ub_n | input | 1 | Upper byte enable (bits 15:8), active low |
| rdata | output | 16 | Read data; zero on undriven lanes |
| drive | output | 2 | Per-lane output drive flag; bit 0 lower, bit 1 upper |
| mode | output | 2 | 00 standby, 01 outputs off, 10 read, 11 write |

## Verification
A wrong decode shows on mode and drive in the same cycle as the pin change, because both outputs are combinational from the controls. A corrupted or misdirected write is the only fault that creates wrong internal state, and it stays hidden until that word is read. For this reason the bench first fills the whole array and then reads back after every write and after every stimulus meant to be ignored. Any lane written when it should not have been then shows as a wrong rdata byte on the very next read of that address.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    localparam int DATA_W = 16;
    localparam int LANES  = 2;
    localparam int LANE_W = DATA_W / LANES;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'b00,
        MODE_NODRIVE = 2'b01,
        MODE_READ    = 2'b10,
        MODE_WRITE   = 2'b11
    } mode_e;

    typedef struct packed {
        logic             sel_lo_n;
        logic             sel_hi;
        logic             out_en_n;
        logic             wr_en_n;
        logic [LANES-1:0] lane_en_n;
    } pin_ctl_t;

    typedef struct packed {
        mode_e            mode;
        logic [LANES-1:0] lane_wr;
        logic [LANES-1:0] lane_rd;
    } access_t;

    function automatic logic chip_picked(pin_ctl_t c);
        return !c.sel_lo_n && c.sel_hi && (c.lane_en_n != {LANES{1'b1}});
    endfunction

endpackage

// File: rtl/sram_ctl_decode.sv
module sram_ctl_decode
    import sram_lane_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_ctl_t ctl,
    output access_t  acc
);

    always_comb begin
        acc = '0;
        if (!chip_picked(ctl))       acc.mode = MODE_STANDBY;
        else if (!ctl.wr_en_n)       acc.mode = MODE_WRITE;
        else if (!ctl.out_en_n)      acc.mode = MODE_READ;
        else                         acc.mode = MODE_NODRIVE;
        if (acc.mode == MODE_WRITE && !rst) acc.lane_wr = ~ctl.lane_en_n;
        if (acc.mode == MODE_READ)          acc.lane_rd = ~ctl.lane_en_n;
    end

    // R2: a deselected part never writes
    assert_deselect_nowrite_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl.sel_lo_n || !ctl.sel_hi) |-> (acc.lane_wr == '0));

    // R3: no lane enabled means no drive and no write
    assert_nolane_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl.lane_en_n == '1) |-> (acc.lane_rd == '0 && acc.lane_wr == '0));

    // R9: never read and write in the same cycle
    assert_rw_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !((acc.lane_rd != '0) && (acc.lane_wr != '0)));

endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane #(
    parameter int ADDR_W = 10,
    parameter int WIDTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  din,
    output logic [WIDTH-1:0]  dout
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr) mem[addr] <= din;
    end

    assign dout = mem[addr];

    // R5: a committed write is visible at that address next cycle
    assert_write_lands_R5: assert property (@(posedge clk) disable iff (rst)
        wr |=> (mem[$past(addr)] == $past(din)));

    // R4: a lane not written keeps its content
    assert_lane_holds_R4: assert property (@(posedge clk) disable iff (rst)
        !wr |=> (mem[$past(addr)] == $past(dout)));

endmodule

// File: rtl/sram_lane_model.sv
module sram_lane_model
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              cs_lo_n,
    input  logic              cs_hi,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              lb_n,
    input  logic              ub_n,
    output logic [15:0]       rdata,
    output logic [1:0]        drive,
    output logic [1:0]        mode
);

    pin_ctl_t ctl;
    access_t  acc;
    logic [LANES-1:0][LANE_W-1:0] lane_q;

    always_comb begin
        ctl.sel_lo_n  = cs_lo_n;
        ctl.sel_hi    = cs_hi;
        ctl.out_en_n  = oe_n;
        ctl.wr_en_n   = we_n;
        ctl.lane_en_n = {ub_n, lb_n};
    end

    sram_ctl_decode u_dec (
        .clk (clk),
        .rst (rst),
        .ctl (ctl),
        .acc (acc)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_byte_lane #(.ADDR_W(ADDR_W), .WIDTH(LANE_W)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .wr   (acc.lane_wr[g]),
            .addr (addr),
            .din  (wdata[g*LANE_W +: LANE_W]),
            .dout (lane_q[g])
        );
        assign rdata[g*LANE_W +: LANE_W] = acc.lane_rd[g] ? lane_q[g] : '0;
    end

    assign drive = acc.lane_rd;
    assign mode  = acc.mode;

    // R6: a driven lane exists only in read mode
    assert_drive_only_read_R6: assert property (@(posedge clk) disable iff (rst)
        (drive != 2'b00) |-> (mode == MODE_READ));

    // R7: undriven lanes read as zero
    assert_undriven_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (!drive[0] |-> rdata[7:0] == 8'h00) and (!drive[1] |-> rdata[15:8] == 8'h00));

    // R2: standby never drives
    assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STANDBY) |-> (drive == 2'b00 && rdata == 16'h0000));

endmodule

// File: tb/sim_sram_lane_model.sv
module sim_sram_lane_model;

    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic          cs_lo_n = 1'b1, cs_hi = 1'b0, oe_n = 1'b1, we_n = 1'b1;
    logic          lb_n = 1'b1, ub_n = 1'b1;
    logic [15:0]   rdata;
    logic [1:0]    drive, mode;

    int errs = 0;
    int checks = 0;
    bit done = 0;
    logic [15:0] model_mem [DEPTH];

    always #2 clk = ~clk;

    sram_lane_model #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .cs_lo_n(cs_lo_n), .cs_hi(cs_hi), .oe_n(oe_n), .we_n(we_n),
        .lb_n(lb_n), .ub_n(ub_n),
        .rdata(rdata), .drive(drive), .mode(mode)
    );

    function automatic logic [15:0] pat(int a, int salt);
        return 16'((a * 40503 + salt * 7919) ^ 16'h3c5a);
    endfunction

    task automatic cmp(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Called just after a falling edge; leaves at the next falling edge.
    task automatic step(string tag, logic c1n, logic c2, logic oen, logic wen,
                        logic lbn, logic ubn, logic r, int a, logic [15:0] d);
        logic sel;
        logic [1:0] emode, edrv;
        logic [15:0] erd;
        cs_lo_n = c1n; cs_hi = c2; oe_n = oen; we_n = wen;
        lb_n = lbn; ub_n = ubn; rst = r; addr = AW'(a); wdata = d;
        #1;
        sel = !c1n && c2 && !(lbn && ubn);
        if (!sel)       emode = 2'b00;
        else if (!wen)  emode = 2'b11;
        else if (!oen)  emode = 2'b10;
        else            emode = 2'b01;
        edrv = (emode == 2'b10) ? {!ubn, !lbn} : 2'b00;
        erd  = 16'h0000;
        if (edrv[0]) erd[7:0]  = model_mem[a][7:0];
        if (edrv[1]) erd[15:8] = model_mem[a][15:8];
        cmp(tag, "mode",  {14'h0, mode},  {14'h0, emode});
        cmp(tag, "drive", {14'h0, drive}, {14'h0, edrv});
        cmp(tag, "rdata", rdata, erd);
        @(posedge clk);
        if (emode == 2'b11 && !r) begin
            if (!lbn) model_mem[a][7:0]  = d[7:0];
            if (!ubn) model_mem[a][15:8] = d[15:8];
        end
        @(negedge clk);
    endtask

    task automatic rd(string tag, int a, logic lbn, logic ubn);
        step(tag, 1'b0, 1'b1, 1'b0, 1'b1, lbn, ubn, 1'b0, a, 16'hffff);
    endtask

    task automatic wr(string tag, int a, logic lbn, logic ubn, logic oen, logic [15:0] d);
        step(tag, 1'b0, 1'b1, oen, 1'b0, lbn, ubn, 1'b0, a, d);
    endtask

    initial begin
        @(negedge clk);
        // R2 reset state: deselected while in reset
        step("R2", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 0, 16'h0);
        step("R2", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 0, 16'h0);

        // R1 / R5: fill whole array with word writes
        for (int a = 0; a < DEPTH; a++) wr("R5", a, 1'b0, 1'b0, 1'b1, pat(a, 1));
        for (int a = 0; a < DEPTH; a += 37) rd("R1", a, 1'b0, 1'b0);
        rd("R1", DEPTH - 1, 1'b0, 1'b0);

        // R4 / R5: byte writes, oe_n low during write
        wr("R5", 5, 1'b0, 1'b1, 1'b0, 16'hab12);
        rd("R4", 5, 1'b0, 1'b0);
        wr("R5", 6, 1'b1, 1'b0, 1'b0, 16'hcd34);
        rd("R4", 6, 1'b0, 1'b0);
        rd("R4", 6, 1'b0, 1'b1);
        rd("R4", 6, 1'b1, 1'b0);

        // R2: deselected by either select, write attempts ignored
        step("R2", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9, 16'hdead);
        step("R2", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9, 16'hbeef);
        rd("R2", 9, 1'b0, 1'b0);

        // R3: no byte enable, write ignored
        step("R3", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10, 16'h1111);
        step("R3", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 10, 16'h0);
        rd("R3", 10, 1'b0, 1'b0);

        // R7: outputs off
        step("R7", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 11, 16'h0);
        step("R7", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 11, 16'h0);

        // R8: write during reset is dropped
        step("R8", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 12, 16'h7777);
        rd("R8", 12, 1'b0, 1'b0);

        // R9: write then read back to back
        wr("R9", 13, 1'b0, 1'b0, 1'b0, 16'h9abc);
        rd("R9", 13, 1'b0, 1'b0);
        wr("R9", 13, 1'b0, 1'b1, 1'b0, 16'h0055);
        rd("R9", 13, 1'b0, 1'b0);

        // R6: random mix of controls over a small address window
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] r8;
            r8 = 8'($urandom);
            step("R6", r8[0] & r8[1], r8[2] | r8[3], r8[4], r8[5] & r8[6], r8[7], 1'($urandom),
                 1'b0, int'($urandom % 32), 16'($urandom));
        end
        for (int a = 0; a < 32; a++) rd("R6", a, 1'b0, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule